// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block sits between a set of peripherals and a processor core. Each peripheral raises a one-cycle pulse when it needs service. The block keeps one small control register per source. That register holds a pending flag and a 3-bit level, where 0 turns the source off and 7 is the most urgent. Every cycle, the block works out which pending source the core should take, if any, and presents the answer on registered outputs.

The core supplies a global enable and its own current 3-bit priority. A source can only win when it is pending, the enable is high, and its level is strictly above the core's priority. Among the sources that qualify, the highest level wins, and a tie goes to the lowest source number. When the core takes the interrupt, it pulses an acknowledge input, and this clears the pending flag of the source currently shown. Software uses a single-register write port. A write always loads the source's level. It can also clear that source's pending flag, but it can never set it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Reset clears every pending flag and every level to 0, and drives `irq_req`, `irq_idx` and `irq_lvl` to 0.
- R2: A high bit of `src_pulse` sets the pending flag of that source on the next rising edge. The flag stays set until it is cleared.
- R3: While `gie` is 0, `irq_req` is 0 one edge later, whatever the pending flags and levels are.
- R4: A pending source qualifies only if its level is strictly greater than `cpu_lvl`. With `cpu_lvl` = 7 nothing qualifies. With `cpu_lvl` = 0, every level from 1 upward qualifies.
- R5: A source whose level is 0 never produces `irq_req`, even while its pending flag is set.
- R6: Among qualifying sources, the one with the highest level is reported on `irq_idx`/`irq_lvl`. When levels are equal, the lowest index wins.
- R7: `ack` high while `irq_req` is 1 clears the pending flag of the source shown on `irq_idx`, on that edge.
- R8: A write (`wr_en`=1) loads `wr_lvl` into the level of source `wr_idx`. If `wr_req` is 0, the write also clears that source's pending flag. If `wr_req` is 1, the flag is left as it was.
- R9: A pulse arriving on the same edge as a clear from software or from `ack` leaves the flag set.
- R10: A write to one source changes neither the level nor the pending flag of any other source. Changes to `gie` or `cpu_lvl` leave all flags and levels untouched.
- R11: The outputs are registered. A change in the pending flags shows up on the outputs one edge after the flag changes, which is two edges after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | NSRC | One-cycle request pulses, one bit per source |
| gie | input | 1 | Global maskable interrupt enable from the core |
| cpu_lvl | input | 3 | Current processor priority level |
| ack | input | 1 | Core accepts the interrupt shown on the outputs |
| wr_en | input | 1 | Software write strobe |
| wr_idx | input | IDXW | Source selected by the write |
| wr_lvl | input | 3 | New level for the selected source |
| wr_req | input | 1 | Pending bit value written (0 clears, 1 keeps) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | IDXW | Index of the winning source |
| irq_lvl | output | 3 | Level of the winning source |

## Verification
A new pulse from a source can land on the same edge as a clear of that source's pending flag. The clear can come either from a software write of 0 or from an acknowledge of that source. The bench provokes both collisions by driving the pulse and the clear in the same cycle. It then judges the result at the outputs two edges later: the source must still be reported as the winner. A separate acknowledge with no pulse shows that the clear path itself works, so the collision result is not simply a dead clear.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC = 8,
  parameter int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            gie,
  input  logic [2:0]      cpu_lvl,
  input  logic            ack,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [2:0]      wr_lvl,
  input  logic            wr_req,
  output logic            irq_req,
  output logic [IDXW-1:0] irq_idx,
  output logic [2:0]      irq_lvl
);

  logic [NSRC-1:0] pend_q;
  logic [2:0]      lvl_q [NSRC];
  logic [NSRC-1:0] clr;
  logic            win_v;
  logic [IDXW-1:0] win_i;
  logic [2:0]      win_l;

  // clear requests from acknowledge or software write of 0
  always_comb begin
    for (int i = 0; i < NSRC; i++)
      clr[i] = (ack && irq_req && irq_idx == IDXW'(i)) ||
               (wr_en && !wr_req && wr_idx == IDXW'(i));
  end

  // highest level wins; strict compare keeps the lowest index on ties
  always_comb begin
    win_v = 1'b0;
    win_i = '0;
    win_l = 3'd0;
    for (int i = 0; i < NSRC; i++) begin
      if (gie && pend_q[i] && lvl_q[i] > cpu_lvl && lvl_q[i] > win_l) begin
        win_v = 1'b1;
        win_i = IDXW'(i);
        win_l = lvl_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= 3'd0;
      irq_req <= 1'b0;
      irq_idx <= '0;
      irq_lvl <= 3'd0;
    end else begin
      pend_q <= src_pulse | (pend_q & ~clr);
      for (int i = 0; i < NSRC; i++)
        if (wr_en && wr_idx == IDXW'(i)) lvl_q[i] <= wr_lvl;
      irq_req <= win_v;
      irq_idx <= win_i;
      irq_lvl <= win_l;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NSRC = 8,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_pulse,
  input logic            gie,
  input logic [2:0]      cpu_lvl,
  input logic            ack,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx,
  input logic            wr_req,
  input logic            irq_req,
  input logic [IDXW-1:0] irq_idx,
  input logic [2:0]      irq_lvl,
  input logic [NSRC-1:0] pend
);

  // R3
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !irq_req);

  // R4
  above_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_lvl > $past(cpu_lvl));

  // R5
  lvl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_lvl != 3'd0);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // R2
    hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_pulse[i] |=> pend[i]);

    // R8
    no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pend[i] && !src_pulse[i] |=> !pend[i]);

    // R7
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack && irq_req && irq_idx == IDXW'(i) && !src_pulse[i] |=> !pend[i]);

    // R8
    sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_req && wr_idx == IDXW'(i) && !src_pulse[i] |=> !pend[i]);
  end

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .gie(gie),
  .cpu_lvl(cpu_lvl), .ack(ack), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_req(wr_req), .irq_req(irq_req), .irq_idx(irq_idx),
  .irq_lvl(irq_lvl), .pend(pend_q)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  localparam int NSRC = 8;
  localparam int IDXW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_pulse = '0;
  logic            gie = 1'b0;
  logic [2:0]      cpu_lvl = 3'd0;
  logic            ack = 1'b0;
  logic            wr_en = 1'b0;
  logic [IDXW-1:0] wr_idx = '0;
  logic [2:0]      wr_lvl = 3'd0;
  logic            wr_req = 1'b1;
  logic            irq_req;
  logic [IDXW-1:0] irq_idx;
  logic [2:0]      irq_lvl;

  int nchk = 0;
  int nbad = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.NSRC(NSRC), .IDXW(IDXW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .gie(gie),
    .cpu_lvl(cpu_lvl), .ack(ack), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_lvl(wr_lvl), .wr_req(wr_req), .irq_req(irq_req),
    .irq_idx(irq_idx), .irq_lvl(irq_lvl)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic er, int ei, int el);
    nchk++;
    if (irq_req !== er || (er && (irq_idx !== IDXW'(ei) || irq_lvl !== 3'(el)))) begin
      nbad++;
      $display("FAIL %s: got req=%0b idx=%0d lvl=%0d, expected req=%0b idx=%0d lvl=%0d",
               tag, irq_req, irq_idx, irq_lvl, er, ei, el);
    end
  endtask

  task automatic pulse(int s);
    src_pulse = NSRC'(1) << s;
    step();
    src_pulse = '0;
    step();
  endtask

  task automatic wr(int s, int l, logic r);
    wr_en = 1'b1; wr_idx = IDXW'(s); wr_lvl = 3'(l); wr_req = r;
    step();
    wr_en = 1'b0; wr_req = 1'b1;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(); step();
    chk("R1 outputs in reset", 1'b0, 0, 0);
    rst_n = 1'b1;
    gie = 1'b1;
    step();
    pulse(3);
    chk("R1 level resets to 0 so pending src3 is silent", 1'b0, 0, 0);
  endtask

  task automatic t_set_and_keep();
    wr(3, 5, 1'b1);
    chk("R8 R2 write of 1 keeps pending src3", 1'b1, 3, 5);
  endtask

  task automatic t_gate();
    gie = 1'b0; step(); step();
    chk("R3 gie low masks", 1'b0, 0, 0);
    gie = 1'b1; step(); step();
    chk("R10 gie change kept pending flag", 1'b1, 3, 5);
  endtask

  task automatic t_cpu_lvl();
    cpu_lvl = 3'd5; step(); step();
    chk("R4 equal level refused", 1'b0, 0, 0);
    cpu_lvl = 3'd4; step(); step();
    chk("R4 level above cpu accepted", 1'b1, 3, 5);
    cpu_lvl = 3'd7; step(); step();
    chk("R4 cpu level 7 masks all", 1'b0, 0, 0);
    cpu_lvl = 3'd0; step(); step();
    chk("R4 cpu level 0 admits", 1'b1, 3, 5);
  endtask

  task automatic t_prio();
    wr(5, 5, 1'b1);
    pulse(5);
    chk("R6 tie goes to lower index", 1'b1, 3, 5);
    wr(6, 7, 1'b1);
    pulse(6);
    chk("R6 highest level wins", 1'b1, 6, 7);
  endtask

  task automatic t_ack();
    ack = 1'b1; step(); ack = 1'b0; step();
    chk("R7 ack clears src6", 1'b1, 3, 5);
    wr(3, 5, 1'b0);
    chk("R8 write 0 clears src3", 1'b1, 5, 5);
    wr(2, 2, 1'b1);
    chk("R10 write to src2 leaves src5", 1'b1, 5, 5);
  endtask

  task automatic t_collide();
    wr_en = 1'b1; wr_idx = 3'd5; wr_lvl = 3'd5; wr_req = 1'b0;
    src_pulse = 8'h20;
    step();
    wr_en = 1'b0; wr_req = 1'b1; src_pulse = '0;
    step();
    chk("R9 pulse beats software clear", 1'b1, 5, 5);
    ack = 1'b1; src_pulse = 8'h20;
    step();
    ack = 1'b0; src_pulse = '0;
    step();
    chk("R9 pulse beats ack clear", 1'b1, 5, 5);
    wr(5, 5, 1'b0);
    chk("R10 src2 never pulsed stays idle", 1'b0, 0, 0);
  endtask

  task automatic t_lvl0_and_timing();
    wr(2, 0, 1'b1);
    pulse(2);
    chk("R5 level 0 source silent", 1'b0, 0, 0);
    wr(2, 1, 1'b1);
    chk("R5 enabling level 1 reveals src2", 1'b1, 2, 1);
    wr(7, 3, 1'b1);
    src_pulse = 8'h80;
    step();
    src_pulse = '0;
    chk("R11 one edge after pulse output unchanged", 1'b1, 2, 1);
    step();
    chk("R11 two edges after pulse src7 shown", 1'b1, 7, 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired across R1 to R11 run");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_set_and_keep();
    t_gate();
    t_cpu_lvl();
    t_prio();
    t_ack();
    t_collide();
    t_lvl0_and_timing();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule